// File: doc/BRIEF.md
# Scatter-Gather Descriptor Fetcher

This block feeds a main DMA channel from a page list kept in host memory. Software hands it a list by giving the list's base address, its length in bytes and two mode flags. The list is made of eight-byte entries. The first 32-bit word of an entry is the start address of a memory page. The second word holds a 16-bit control field in its upper half and a 16-bit transfer count (in words) in its lower half.

The fetcher keeps two list registers. A "next" slot takes software's write. A "current" slot is the list being walked. When the current list has no bytes left, a waiting next list moves into current, and the next slot is free for software again. An optional interrupt flags that moment. While current bytes remain and the main channel's next slot is empty, the block reads one entry over a simple request/valid memory read port. It reads the address word first and the count word second, with one read in flight at a time. It then loads the entry into the main channel's next slot. The main data mover takes that slot with a one-cycle pulse.

Top module: `sg_desc_fetch`

## Requirements
- R1: While and after reset, `sg_nxt_empty` and `mn_nxt_empty` read 1 and `mem_req`, `sg_err` and `sg_irq` read 0.
- R2: A list write whose byte count is not a multiple of 8 (any of count bits 2:0 set) is rejected. `sg_err` reads 1 after the write edge and the next slot stays empty.
- R3: A list write while the next slot is full is rejected with `sg_err`=1 and leaves the waiting list unchanged. An accepted write clears `sg_err` and `sg_irq` and makes `sg_nxt_empty` read 0 after the write edge.
- R4: When the current list has zero bytes left and the next slot is full, the next list becomes current on the following edge and `sg_nxt_empty` returns to 1.
- R5: If the promoted list was written with `sg_wr_irq_en`=1, `sg_irq` reads 1 from the promotion edge until the next accepted write.
- R6: Each entry is read as two single reads, the address word at the entry address and then the count word at entry address + 4. The first entry address is the list address with bits 2:0 cleared. `mem_req` is held with a stable `mem_addr` until `mem_rvalid`.
- R7: On the edge that delivers the count word, `mn_nxt_addr` takes the first word, `mn_nxt_ctl` the count word's bits 31:16 and `mn_nxt_cnt` its bits 15:0, and `mn_nxt_empty` reads 0.
- R8: No read is issued while `mn_nxt_empty` is 0. A `mn_take` pulse empties the main next slot on its edge, and fetching then resumes.
- R9: A list of B bytes yields exactly B/8 entries at list address + 8·k in order. After the last entry, no read is issued until another list is promoted.
- R10: `mn_idle` reads 1 exactly when the main next slot is empty and `mv_busy` is 0.
- R11: `sg_burst` shows the burst flag written with the list that is currently current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sg_wr | input | 1 | One-cycle list write strobe |
| sg_wr_addr | input | 32 | List base address |
| sg_wr_bytes | input | 16 | List length in bytes |
| sg_wr_irq_en | input | 1 | Raise interrupt when this list is promoted |
| sg_wr_burst | input | 1 | Burst mode flag carried with the list |
| sg_nxt_empty | output | 1 | Next list slot is free |
| sg_err | output | 1 | Last list write was rejected |
| sg_irq | output | 1 | Interrupt: a list with interrupt enabled was promoted |
| sg_burst | output | 1 | Burst flag of the current list |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| mn_nxt_addr | output | 32 | Main channel next page address |
| mn_nxt_ctl | output | 16 | Main channel next control field |
| mn_nxt_cnt | output | 16 | Main channel next word count |
| mn_nxt_empty | output | 1 | Main channel next slot is empty |
| mn_take | input | 1 | Data mover takes the main next slot |
| mv_busy | input | 1 | Data mover is transferring |
| mn_idle | output | 1 | Main next empty and data mover idle |

## Verification
The bench goes after the two rejection paths. A design that checked only alignment would let a write over a waiting list overwrite it, so the bench later sees the wrong entry addresses. It also goes after back-pressure from a full main slot: a fetcher that ignored it would raise `mem_req` during the hold window. List boundaries are checked by counting entries and watching for a stray read past the end, which catches an off-by-one in the byte decrement. Promotion while the previous list is still draining shows whether the interrupt and burst flag follow the promoted list rather than the write. A reset in the middle of an entry read shows whether the read sequencing restarts cleanly.

// File: rtl/sgdf_pkg.sv
package sgdf_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 16;
    localparam int CTL_W      = DATA_W - CNT_W;
    localparam int DESC_BYTES = 8;
    localparam int WORD_BYTES = 4;
    localparam int ALIGN_W    = $clog2(DESC_BYTES);

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_ADDR = 2'd1,
        FS_CNT  = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  bytes;
        logic              irq_en;
        logic              burst;
    } list_t;

    typedef struct packed {
        logic [ADDR_W-1:0] page;
        logic [CTL_W-1:0]  ctl;
        logic [CNT_W-1:0]  words;
    } desc_t;

    function automatic logic bytes_whole(input logic [CNT_W-1:0] b);
        return b[ALIGN_W-1:0] == '0;
    endfunction

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    endfunction

    function automatic desc_t make_desc(input logic [ADDR_W-1:0] page,
                                        input logic [DATA_W-1:0] cnt_word);
        desc_t d;
        d.page  = page;
        d.ctl   = cnt_word[DATA_W-1:CNT_W];
        d.words = cnt_word[CNT_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/sgdf_list_regs.sv
module sgdf_list_regs
    import sgdf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  list_t wr_list,
    input  logic  fetch_adv,
    output list_t cur,
    output logic  nxt_empty,
    output logic  err,
    output logic  irq
);

    localparam logic [CNT_W-1:0]  STEP_BYTES = CNT_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] STEP_ADDR  = ADDR_W'(DESC_BYTES);

    list_t nxt_q;
    list_t cur_q;
    logic  nxt_full_q;
    logic  err_q;
    logic  irq_q;
    logic  accept;
    logic  promote;

    assign accept  = wr && bytes_whole(wr_list.bytes) && !nxt_full_q;
    assign promote = nxt_full_q && (cur_q.bytes == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_q      <= '0;
            cur_q      <= '0;
            nxt_full_q <= 1'b0;
            err_q      <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            if (wr) begin
                err_q <= !accept;
            end
            if (accept) begin
                nxt_q        <= wr_list;
                nxt_q.addr   <= align_down(wr_list.addr);
                nxt_full_q   <= 1'b1;
                irq_q        <= 1'b0;
            end else if (promote) begin
                cur_q      <= nxt_q;
                nxt_full_q <= 1'b0;
                if (nxt_q.irq_en) begin
                    irq_q <= 1'b1;
                end
            end
            if (fetch_adv && !promote) begin
                cur_q.addr  <= cur_q.addr + STEP_ADDR;
                cur_q.bytes <= cur_q.bytes - STEP_BYTES;
            end
        end
    end

    assign cur       = cur_q;
    assign nxt_empty = !nxt_full_q;
    assign err       = err_q;
    assign irq       = irq_q;

endmodule

// File: rtl/sgdf_fetch_fsm.sv
module sgdf_fetch_fsm
    import sgdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  cur_bytes,
    input  logic              mn_empty,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              load,
    output desc_t             desc
);

    localparam logic [ADDR_W-1:0] CNT_OFS = ADDR_W'(WORD_BYTES);

    fetch_state_e      state_q;
    fetch_state_e      state_d;
    logic [ADDR_W-1:0] page_q;

    always_comb begin
        state_d  = state_q;
        mem_req  = 1'b0;
        mem_addr = cur_addr;
        load     = 1'b0;
        unique case (state_q)
            FS_IDLE: begin
                if ((cur_bytes != '0) && mn_empty) begin
                    state_d = FS_ADDR;
                end
            end
            FS_ADDR: begin
                mem_req = 1'b1;
                if (mem_rvalid) begin
                    state_d = FS_CNT;
                end
            end
            FS_CNT: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + CNT_OFS;
                if (mem_rvalid) begin
                    load    = 1'b1;
                    state_d = FS_IDLE;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            page_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == FS_ADDR) && mem_rvalid) begin
                page_q <= mem_rdata;
            end
        end
    end

    assign desc = make_desc(page_q, mem_rdata);

endmodule

// File: rtl/sgdf_main_next.sv
module sgdf_main_next
    import sgdf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  desc_t desc_in,
    input  logic  take,
    output desc_t desc_out,
    output logic  empty
);

    desc_t desc_q;
    logic  full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '0;
            full_q <= 1'b0;
        end else if (load) begin
            desc_q <= desc_in;
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign desc_out = desc_q;
    assign empty    = !full_q;

endmodule

// File: rtl/sg_desc_fetch.sv
module sg_desc_fetch
    import sgdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sg_wr,
    input  logic [ADDR_W-1:0] sg_wr_addr,
    input  logic [CNT_W-1:0]  sg_wr_bytes,
    input  logic              sg_wr_irq_en,
    input  logic              sg_wr_burst,
    output logic              sg_nxt_empty,
    output logic              sg_err,
    output logic              sg_irq,
    output logic              sg_burst,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mn_nxt_addr,
    output logic [CTL_W-1:0]  mn_nxt_ctl,
    output logic [CNT_W-1:0]  mn_nxt_cnt,
    output logic              mn_nxt_empty,
    input  logic              mn_take,
    input  logic              mv_busy,
    output logic              mn_idle
);

    list_t wr_list;
    list_t cur_list;
    logic  entry_load;
    desc_t fetched;
    desc_t mn_desc;

    always_comb begin
        wr_list.addr   = sg_wr_addr;
        wr_list.bytes  = sg_wr_bytes;
        wr_list.irq_en = sg_wr_irq_en;
        wr_list.burst  = sg_wr_burst;
    end

    sgdf_list_regs u_list (
        .clk       (clk),
        .rst       (rst),
        .wr        (sg_wr),
        .wr_list   (wr_list),
        .fetch_adv (entry_load),
        .cur       (cur_list),
        .nxt_empty (sg_nxt_empty),
        .err       (sg_err),
        .irq       (sg_irq)
    );

    sgdf_fetch_fsm u_fetch (
        .clk        (clk),
        .rst        (rst),
        .cur_addr   (cur_list.addr),
        .cur_bytes  (cur_list.bytes),
        .mn_empty   (mn_nxt_empty),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .load       (entry_load),
        .desc       (fetched)
    );

    sgdf_main_next u_mnext (
        .clk      (clk),
        .rst      (rst),
        .load     (entry_load),
        .desc_in  (fetched),
        .take     (mn_take),
        .desc_out (mn_desc),
        .empty    (mn_nxt_empty)
    );

    assign sg_burst    = cur_list.burst;
    assign mn_nxt_addr = mn_desc.page;
    assign mn_nxt_ctl  = mn_desc.ctl;
    assign mn_nxt_cnt  = mn_desc.words;
    assign mn_idle     = mn_nxt_empty && !mv_busy;

endmodule

// File: rtl/sgdf_chk.sv
module sgdf_chk
    import sgdf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sg_wr,
    input logic [CNT_W-1:0]  sg_wr_bytes,
    input logic              sg_nxt_empty,
    input logic              sg_err,
    input logic              sg_irq,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              mn_nxt_empty
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sg_nxt_empty && mn_nxt_empty && !mem_req && !sg_err && !sg_irq));

    a_r2_reject_odd: assert property (@(posedge clk) disable iff (rst)
        (sg_wr && (sg_wr_bytes[ALIGN_W-1:0] != '0)) |=> sg_err);

    a_r3_accept: assert property (@(posedge clk) disable iff (rst)
        (sg_wr && (sg_wr_bytes[ALIGN_W-1:0] == '0) && sg_nxt_empty)
        |=> (!sg_nxt_empty && !sg_err && !sg_irq));

    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r6_entry_start: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> (mem_addr[ALIGN_W-1:0] == '0));

    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid && mem_addr[ALIGN_W-1]) |=> !mn_nxt_empty);

    a_r8_backpressure: assert property (@(posedge clk) disable iff (rst)
        (!mn_nxt_empty && !mem_req) |=> !mem_req);

endmodule

bind sg_desc_fetch sgdf_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sg_wr        (sg_wr),
    .sg_wr_bytes  (sg_wr_bytes),
    .sg_nxt_empty (sg_nxt_empty),
    .sg_err       (sg_err),
    .sg_irq       (sg_irq),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .mn_nxt_empty (mn_nxt_empty)
);

// File: tb/sg_desc_fetch_tb.sv
`timescale 1ns/1ps
module sg_desc_fetch_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sg_wr = 1'b0;
    logic [31:0] sg_wr_addr = '0;
    logic [15:0] sg_wr_bytes = '0;
    logic        sg_wr_irq_en = 1'b0;
    logic        sg_wr_burst = 1'b0;
    logic        sg_nxt_empty, sg_err, sg_irq, sg_burst;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mn_nxt_addr;
    logic [15:0] mn_nxt_ctl, mn_nxt_cnt;
    logic        mn_nxt_empty;
    logic        mn_take = 1'b0;
    logic        mv_busy = 1'b0;
    logic        mn_idle;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sg_desc_fetch u_dut (.*);

    // list table: {addr[63:32], bytes[31:16], 14'b0, irq_en[1], burst[0]}
    localparam int NLIST = 4;
    localparam logic [63:0] LISTS [NLIST] = '{
        {32'h0000_1000, 16'h0018, 14'b0, 1'b1, 1'b0},
        {32'h0002_0040, 16'h0008, 14'b0, 1'b0, 1'b1},
        {32'h0000_8000, 16'h0020, 14'b0, 1'b1, 1'b1},
        {32'h0001_0000, 16'h0010, 14'b0, 1'b0, 1'b0}
    };

    function automatic logic [31:0] memw(input logic [31:0] a);
        return (a * 32'd2654435761) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected read address queue, filled by the bench, consumed by the responder
    logic [31:0] exp_rd [0:255];
    int          rd_wr_idx = 0;
    int          rd_idx    = 0;
    int          dly       = 0;

    always @(negedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            dly        <= 0;
            rd_idx     <= rd_wr_idx;
        end else if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
        end else if (mem_req) begin
            if (dly == 2) begin
                dly        <= 0;
                mem_rvalid <= 1'b1;
                mem_rdata  <= memw(mem_addr);
                chk(rd_idx < rd_wr_idx && mem_addr == exp_rd[rd_idx[7:0]],
                    "R6 read address order", mem_addr, exp_rd[rd_idx[7:0]]);
                rd_idx <= rd_idx + 1;
            end else begin
                dly <= dly + 1;
            end
        end
    end

    task automatic write_list(input logic [31:0] a, input logic [15:0] b,
                              input bit irq, input bit burst, input bit accepted);
        sg_wr        = 1'b1;
        sg_wr_addr   = a;
        sg_wr_bytes  = b;
        sg_wr_irq_en = irq;
        sg_wr_burst  = burst;
        if (accepted) begin
            for (int k = 0; k < int'(b) / 8; k++) begin
                exp_rd[rd_wr_idx[7:0]]         = a + 32'(8 * k);
                exp_rd[(rd_wr_idx + 1) % 256]  = a + 32'(8 * k + 4);
                rd_wr_idx = rd_wr_idx + 2;
            end
        end
        @(negedge clk);
        sg_wr = 1'b0;
    endtask

    task automatic walk(input logic [31:0] base, input int n);
        for (int e = 0; e < n; e++) begin
            int t = 0;
            while (mn_nxt_empty && t < 60) begin
                @(negedge clk);
                t++;
            end
            chk(mn_nxt_addr == memw(base + 32'(8 * e)), "R7 page address",
                mn_nxt_addr, memw(base + 32'(8 * e)));
            chk({mn_nxt_ctl, mn_nxt_cnt} == memw(base + 32'(8 * e + 4)),
                "R7 control and count", {mn_nxt_ctl, mn_nxt_cnt},
                memw(base + 32'(8 * e + 4)));
            repeat (4) @(negedge clk);
            chk(!mem_req && !mn_nxt_empty, "R8 no read while main next full",
                {30'b0, mem_req, mn_nxt_empty}, 32'h0);
            chk(!mn_idle, "R10 idle low while main next full", mn_idle, 0);
            mn_take = 1'b1;
            @(negedge clk);
            mn_take = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sg_nxt_empty && mn_nxt_empty && !mem_req && !sg_err && !sg_irq,
            "R1 reset state", {27'b0, sg_nxt_empty, mn_nxt_empty, mem_req, sg_err, sg_irq},
            32'h18);
        rst = 1'b0;
        @(negedge clk);
        chk(mn_idle, "R10 idle when empty and mover idle", mn_idle, 1);
        mv_busy = 1'b1;
        #1;
        chk(!mn_idle, "R10 idle low when mover busy", mn_idle, 0);
        mv_busy = 1'b0;

        // table-driven list walk
        for (int i = 0; i < NLIST; i++) begin
            logic [31:0] a;
            logic [15:0] b;
            a = LISTS[i][63:32];
            b = LISTS[i][31:16];
            write_list(a, b, LISTS[i][1], LISTS[i][0], 1'b1);
            chk(!sg_nxt_empty && !sg_err && !sg_irq, "R3 accepted write",
                {29'b0, sg_nxt_empty, sg_err, sg_irq}, 32'h0);
            @(negedge clk);
            chk(sg_nxt_empty, "R4 promotion frees next slot", sg_nxt_empty, 1);
            chk(sg_irq == LISTS[i][1], "R5 interrupt on promotion", sg_irq,
                {31'b0, LISTS[i][1]});
            chk(sg_burst == LISTS[i][0], "R11 burst flag of current list", sg_burst,
                {31'b0, LISTS[i][0]});
            walk(a, int'(b) / 8);
            repeat (8) @(negedge clk);
            chk(!mem_req && mn_nxt_empty, "R9 no read after list end",
                {30'b0, mem_req, mn_nxt_empty}, 32'h1);
            chk(rd_idx == rd_wr_idx, "R9 entry count", rd_idx, rd_wr_idx);
        end

        // misaligned length
        write_list(32'h0000_4000, 16'h000C, 1'b0, 1'b0, 1'b0);
        chk(sg_err && sg_nxt_empty, "R2 odd length rejected",
            {30'b0, sg_err, sg_nxt_empty}, 32'h3);
        repeat (6) @(negedge clk);
        chk(!mem_req && mn_nxt_empty, "R2 rejected list not fetched",
            {30'b0, mem_req, mn_nxt_empty}, 32'h1);

        // write while next slot full, second list waits behind the first
        write_list(32'h0003_0000, 16'h0010, 1'b0, 1'b0, 1'b1);
        chk(!sg_err, "R3 accepted write clears error", sg_err, 0);
        repeat (12) @(negedge clk);
        write_list(32'h0004_0000, 16'h0008, 1'b1, 1'b1, 1'b1);
        chk(!sg_nxt_empty, "R3 next slot held while current busy", sg_nxt_empty, 0);
        write_list(32'h0005_0000, 16'h0008, 1'b0, 1'b0, 1'b0);
        chk(sg_err && !sg_nxt_empty, "R3 write over full slot rejected",
            {30'b0, sg_err, sg_nxt_empty}, 32'h2);
        chk(!sg_burst && !sg_irq, "R11 burst follows current not written list",
            {30'b0, sg_burst, sg_irq}, 32'h0);
        walk(32'h0003_0000, 2);
        chk(sg_irq && sg_burst && sg_nxt_empty, "R5 waiting list promoted after drain",
            {29'b0, sg_irq, sg_burst, sg_nxt_empty}, 32'h7);
        walk(32'h0004_0000, 1);
        repeat (8) @(negedge clk);
        chk(rd_idx == rd_wr_idx && !mem_req, "R9 rejected list never read",
            rd_idx, rd_wr_idx);

        // reset in the middle of an entry read
        write_list(32'h0006_0000, 16'h0010, 1'b1, 1'b0, 1'b1);
        walk(32'h0006_0000, 1);
        @(negedge clk);
        chk(mem_req, "R8 fetch resumes after take", mem_req, 1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(sg_nxt_empty && mn_nxt_empty && !mem_req && !sg_err && !sg_irq,
            "R1 mid-read reset", {27'b0, sg_nxt_empty, mn_nxt_empty, mem_req, sg_err, sg_irq},
            32'h18);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        write_list(32'h0007_0008, 16'h0008, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        walk(32'h0007_0008, 1);
        repeat (6) @(negedge clk);
        chk(rd_idx == rd_wr_idx, "R6 clean restart after reset", rd_idx, rd_wr_idx);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule